// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block closes out every floating-point operation. It takes the five IEEE exception flags the operation raised, the present floating-point status word and the present program-counter pair. One cycle later it returns the updated status word, the updated program-counter pair and one of two outcomes: a trap request, or permission to step past the instruction.

A trap is taken when any raised flag also has its enable bit set in the status word. In that case the flags are first reduced to the enabled ones, and then to a single flag by fixed priority. The current-exception field receives that one flag, the accrued field is left as it was, and the trap-type field is set to the IEEE-exception code. With no trap, the current field takes all the raised flags, the accrued field gathers them, and the program counter moves on.

Top module: `fpx_status_recorder`

## Requirements
- R1: While reset is held and on the first edge after it, `done`, `trap_req` and `pc_advance` are low and `stat_out`, `pc_cur_out` and `pc_nxt_out` are zero.
- R2: Flag bit order is invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0. The trap-enable mask sits at status bits 27:23 in the same order. A trap is taken exactly when (flags AND enables) is nonzero.
- R3: On a trap, the resulting flag vector is the single highest-numbered bit of (flags AND enables). This gives the priority invalid, then overflow, then underflow, then divide-by-zero, then inexact.
- R4: The current-exception field, status bits 4:0, is always overwritten with the resulting flag vector. Without a trap that vector is the raw flags.
- R5: The accrued field, status bits 9:5, becomes old OR resulting flags when there is no trap, and is unchanged on a trap.
- R6: On a trap the trap-type field, status bits 16:14, is set to 1. Without a trap it is unchanged.
- R7: Without a trap, `pc_cur_out` equals `pc_nxt_in` and `pc_nxt_out` equals `pc_nxt_in` + 4, modulo 2^64. On a trap both PC outputs equal the PC inputs.
- R8: An operation with no raised flags clears the current field and asserts `pc_advance`.
- R9: Outputs update on the edge after `op_valid` is sampled high. `done` is high for exactly that one cycle per operation, back-to-back operations included. `trap_req` and `pc_advance` are high only with `done`, and exactly one of them is high then.
- R10: All status bits outside the enable, trap-type, accrued and current fields pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation has completed; sample the inputs |
| op_flags | input | 5 | Raised IEEE exception flags |
| stat_in | input | 64 | Present status word |
| pc_cur_in | input | 64 | Present program counter |
| pc_nxt_in | input | 64 | Present next program counter |
| done | output | 1 | One-cycle pulse: the outputs hold a new result |
| trap_req | output | 1 | An enabled exception requires a trap |
| pc_advance | output | 1 | No trap; step past the instruction |
| stat_out | output | 64 | Updated status word |
| pc_cur_out | output | 64 | Updated program counter |
| pc_nxt_out | output | 64 | Updated next program counter |

## Verification
Priority selection and the trap decision fall in the same cycle whenever several raised flags are enabled at once. The accrued merge also falls in that cycle, because it must be suppressed by the same decision. The vector table provokes this with all five flags raised and enabled, and with mixed patterns where disabled higher-priority flags sit beside enabled lower ones. Each case is judged on the whole status word: the current field must hold one bit, the accrued field must hold its old value, and the PC pair must hold still.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
   localparam int FPX_FLAG_W  = 5;
   // flag positions; higher index wins when a trap narrows the set
   localparam int FPX_F_INVAL = 4;
   localparam int FPX_F_OVFL  = 3;
   localparam int FPX_F_UNFL  = 2;
   localparam int FPX_F_DIVZ  = 1;
   localparam int FPX_F_INEX  = 0;
   typedef logic [FPX_FLAG_W-1:0] fpx_flags_t;
endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
   parameter int W         = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [W-1:0] req,
   output logic [W-1:0] grant
);
   if (W < 1) begin : g_bad_w
      $error("fpx_prio_pick: W must be at least 1");
   end

   logic [W:0] seen;

   if (MSB_FIRST) begin : g_msb
      assign seen[W] = 1'b0;
      for (genvar i = W - 1; i >= 0; i--) begin : g_bit
         assign grant[i] = req[i] & ~seen[i+1];
         assign seen[i]  = seen[i+1] | req[i];
      end
   end else begin : g_lsb
      assign seen[0] = 1'b0;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign grant[i]  = req[i] & ~seen[i];
         assign seen[i+1] = seen[i] | req[i];
      end
   end
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval #(
   parameter int W = 5
) (
   input  logic [W-1:0] flags,
   input  logic [W-1:0] enables,
   output logic         trap,
   output logic [W-1:0] result
);
   logic [W-1:0] masked;
   logic [W-1:0] single;

   assign masked = flags & enables;
   assign trap   = |masked;

   fpx_prio_pick #(.W(W), .MSB_FIRST(1'b1)) u_pick (
      .req   (masked),
      .grant (single)
   );

   assign result = trap ? single : flags;
endmodule

// File: rtl/fpx_stat_merge.sv
module fpx_stat_merge #(
   parameter int STAT_W  = 64,
   parameter int W       = 5,
   parameter int CUR_LSB = 0,
   parameter int ACC_LSB = 5,
   parameter int TT_LSB  = 14,
   parameter int TT_W    = 3,
   parameter int TT_IEEE = 1
) (
   input  logic [STAT_W-1:0] stat_in,
   input  logic [W-1:0]      result,
   input  logic              trap,
   output logic [STAT_W-1:0] stat_new
);
   localparam logic [TT_W-1:0] TT_CODE = TT_W'(TT_IEEE);

   always_comb begin
      stat_new = stat_in;
      stat_new[CUR_LSB +: W] = result;
      if (trap) begin
         stat_new[TT_LSB +: TT_W] = TT_CODE;
      end else begin
         stat_new[ACC_LSB +: W] = stat_in[ACC_LSB +: W] | result;
      end
   end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
   parameter int PC_W    = 64,
   parameter int PC_STEP = 4
) (
   input  logic            hold,
   input  logic [PC_W-1:0] pc_cur,
   input  logic [PC_W-1:0] pc_nxt,
   output logic [PC_W-1:0] new_cur,
   output logic [PC_W-1:0] new_nxt
);
   localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

   assign new_cur = hold ? pc_cur : pc_nxt;
   assign new_nxt = hold ? pc_nxt : pc_nxt + STEP;
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder #(
   parameter int STAT_W  = 64,
   parameter int PC_W    = 64,
   parameter int FLAG_W  = fpx_pkg::FPX_FLAG_W,
   parameter int CUR_LSB = 0,
   parameter int ACC_LSB = 5,
   parameter int TT_LSB  = 14,
   parameter int TT_W    = 3,
   parameter int EN_LSB  = 23,
   parameter int TT_IEEE = 1,
   parameter int PC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [FLAG_W-1:0] op_flags,
   input  logic [STAT_W-1:0] stat_in,
   input  logic [PC_W-1:0]   pc_cur_in,
   input  logic [PC_W-1:0]   pc_nxt_in,
   output logic              done,
   output logic              trap_req,
   output logic              pc_advance,
   output logic [STAT_W-1:0] stat_out,
   output logic [PC_W-1:0]   pc_cur_out,
   output logic [PC_W-1:0]   pc_nxt_out
);
   localparam logic [PC_W-1:0]   STEP    = PC_W'(PC_STEP);
   localparam logic [TT_W-1:0]   TT_CODE = TT_W'(TT_IEEE);

   // elaboration-time parameter checks
   if (EN_LSB + FLAG_W > STAT_W) begin : g_bad_en
      $error("enable field exceeds status width");
   end
   if (ACC_LSB < CUR_LSB + FLAG_W) begin : g_bad_acc
      $error("accrued field overlaps current field");
   end
   if (TT_LSB < ACC_LSB + TT_W - TT_W + FLAG_W) begin : g_bad_tt
      $error("trap-type field overlaps accrued field");
   end
   if (EN_LSB < TT_LSB + TT_W) begin : g_bad_en_tt
      $error("enable field overlaps trap-type field");
   end
   if (TT_IEEE < 1 || TT_IEEE >= (1 << TT_W)) begin : g_bad_code
      $error("trap-type code does not fit its field");
   end
   if (PC_STEP <= 0) begin : g_bad_step
      $error("PC step must be positive");
   end

   logic [FLAG_W-1:0] enables;
   logic [FLAG_W-1:0] result;
   logic              trap;
   logic [STAT_W-1:0] stat_new;
   logic [PC_W-1:0]   cur_new;
   logic [PC_W-1:0]   nxt_new;

   assign enables = stat_in[EN_LSB +: FLAG_W];

   fpx_trap_eval #(.W(FLAG_W)) u_eval (
      .flags   (op_flags),
      .enables (enables),
      .trap    (trap),
      .result  (result)
   );

   fpx_stat_merge #(
      .STAT_W  (STAT_W),
      .W       (FLAG_W),
      .CUR_LSB (CUR_LSB),
      .ACC_LSB (ACC_LSB),
      .TT_LSB  (TT_LSB),
      .TT_W    (TT_W),
      .TT_IEEE (TT_IEEE)
   ) u_merge (
      .stat_in  (stat_in),
      .result   (result),
      .trap     (trap),
      .stat_new (stat_new)
   );

   fpx_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
      .hold    (trap),
      .pc_cur  (pc_cur_in),
      .pc_nxt  (pc_nxt_in),
      .new_cur (cur_new),
      .new_nxt (nxt_new)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done       <= 1'b0;
         trap_req   <= 1'b0;
         pc_advance <= 1'b0;
         stat_out   <= '0;
         pc_cur_out <= '0;
         pc_nxt_out <= '0;
      end else begin
         done       <= op_valid;
         trap_req   <= op_valid & trap;
         pc_advance <= op_valid & ~trap;
         if (op_valid) begin
            stat_out   <= stat_new;
            pc_cur_out <= cur_new;
            pc_nxt_out <= nxt_new;
         end
      end
   end

   // assertions
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (trap_req ^ pc_advance)); // R9
   AST_NO_STRAY_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!trap_req && !pc_advance)); // R9
   AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> done); // R9
   AST_TRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (trap_req == |($past(op_flags) & $past(stat_in[EN_LSB +: FLAG_W])))); // R2
   AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> ($countones(stat_out[CUR_LSB +: FLAG_W]) == 1)); // R3
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (stat_out[ACC_LSB +: FLAG_W] == $past(stat_in[ACC_LSB +: FLAG_W]))); // R5
   AST_TT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (stat_out[TT_LSB +: TT_W] == TT_CODE)); // R6
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pc_advance |-> (pc_nxt_out == pc_cur_out + STEP)); // R7
   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (pc_cur_out == $past(pc_cur_in) && pc_nxt_out == $past(pc_nxt_in))); // R7
endmodule

// File: tb/fpx_status_recorder_bench.sv
`timescale 1ns/1ps
module fpx_status_recorder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_flags = '0;
   logic [63:0] stat_in = '0;
   logic [63:0] pc_cur_in = '0;
   logic [63:0] pc_nxt_in = '0;
   logic        done, trap_req, pc_advance;
   logic [63:0] stat_out, pc_cur_out, pc_nxt_out;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fpx_status_recorder u_fpx_status_recorder (
      .clk, .rst_n, .op_valid, .op_flags, .stat_in, .pc_cur_in, .pc_nxt_in,
      .done, .trap_req, .pc_advance, .stat_out, .pc_cur_out, .pc_nxt_out
   );

   // other status bits: none inside 27:23, 16:14, 9:0
   localparam logic [63:0] OTHER   = 64'hF0F0_0000_F062_2C00;
   localparam logic [4:0]  ACC_OLD = 5'b00100;
   localparam logic [4:0]  CUR_OLD = 5'b11010;
   localparam logic [2:0]  TT_OLD  = 3'b110;

   // {flags, enables, expected current field, expected trap}
   localparam logic [15:0] VEC [0:7] = '{
      {5'b00000, 5'b11111, 5'b00000, 1'b0},
      {5'b10101, 5'b00000, 5'b10101, 1'b0},
      {5'b11111, 5'b11111, 5'b10000, 1'b1},
      {5'b01110, 5'b00110, 5'b00100, 1'b1},
      {5'b00011, 5'b00001, 5'b00001, 1'b1},
      {5'b01001, 5'b10110, 5'b01001, 1'b0},
      {5'b00110, 5'b00010, 5'b00010, 1'b1},
      {5'b01100, 5'b01000, 5'b01000, 1'b1}
   };

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_stat(input logic [4:0] en);
      return OTHER | (64'(en) << 23) | (64'(TT_OLD) << 14) | (64'(ACC_OLD) << 5) | 64'(CUR_OLD);
   endfunction

   function automatic logic [63:0] exp_stat(input logic [4:0] en, input logic [4:0] cur, input bit trp);
      logic [4:0] acc = trp ? ACC_OLD : (ACC_OLD | cur);
      logic [2:0] tt  = trp ? 3'd1 : TT_OLD;
      return OTHER | (64'(en) << 23) | (64'(tt) << 14) | (64'(acc) << 5) | 64'(cur);
   endfunction

   task automatic drive(input logic [4:0] fl, input logic [4:0] en,
                        input logic [63:0] pc, input logic [63:0] pn);
      op_valid  = 1'b1;
      op_flags  = fl;
      stat_in   = mk_stat(en);
      pc_cur_in = pc;
      pc_nxt_in = pn;
   endtask

   task automatic check_result(input logic [4:0] en, input logic [4:0] cur, input bit trp,
                               input logic [63:0] pc, input logic [63:0] pn);
      chk("R9 done", 64'(done), 64'd1);
      chk("R2 trap_req", 64'(trap_req), 64'(trp));
      chk("R9 pc_advance", 64'(pc_advance), 64'(!trp));
      chk("R3/R4 current field", stat_out[4:0], 64'(cur));
      chk("R5 accrued field", stat_out[9:5], trp ? 64'(ACC_OLD) : 64'(ACC_OLD | cur));
      chk("R6 trap-type field", stat_out[16:14], trp ? 64'd1 : 64'(TT_OLD));
      chk("R10 whole status", stat_out, exp_stat(en, cur, trp));
      chk("R7 pc_cur_out", pc_cur_out, trp ? pc : pn);
      chk("R7 pc_nxt_out", pc_nxt_out, trp ? pn : pn + 64'd4);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 done in reset", 64'(done), 64'd0);
      chk("R1 trap_req in reset", 64'(trap_req), 64'd0);
      chk("R1 pc_advance in reset", 64'(pc_advance), 64'd0);
      chk("R1 stat_out in reset", stat_out, 64'd0);
      chk("R1 pc outputs in reset", pc_cur_out | pc_nxt_out, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", 64'({done, trap_req, pc_advance}), 64'd0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         logic [4:0]  fl  = VEC[i][15:11];
         logic [4:0]  en  = VEC[i][10:6];
         logic [4:0]  cur = VEC[i][5:1];
         bit          trp = VEC[i][0];
         logic [63:0] pc  = 64'h1000 + 64'(i * 16);
         logic [63:0] pn  = pc + 64'd8;
         drive(fl, en, pc, pn);
         @(negedge clk);
         op_valid = 1'b0;
         check_result(en, cur, trp, pc, pn);
         @(negedge clk);
         chk("R9 done drops", 64'({done, trap_req, pc_advance}), 64'd0);
      end

      // R8: no flags raised clears current field and advances
      drive(5'b00000, 5'b00000, 64'h2000, 64'h2004);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R8 current cleared", stat_out[4:0], 64'd0);
      chk("R8 advance", 64'(pc_advance), 64'd1);
      @(negedge clk);

      // R9: back-to-back operations, trap then advance
      drive(5'b10001, 5'b00001, 64'h3000, 64'h3004);
      @(negedge clk);
      drive(5'b00010, 5'b00000, 64'h3100, 64'h3104);
      check_result(5'b00001, 5'b00001, 1'b1, 64'h3000, 64'h3004);
      @(negedge clk);
      op_valid = 1'b0;
      check_result(5'b00000, 5'b00010, 1'b0, 64'h3100, 64'h3104);
      @(negedge clk);
      chk("R9 done after burst", 64'(done), 64'd0);

      // R7: next PC wraps at the top of the address space
      drive(5'b00001, 5'b00000, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R7 pc wrap cur", pc_cur_out, 64'hFFFF_FFFF_FFFF_FFFC);
      chk("R7 pc wrap nxt", pc_nxt_out, 64'h0);
      @(negedge clk);

      // R2: disabled invalid beside enabled inexact still traps, keeps inexact
      drive(5'b10001, 5'b01111, 64'h4000, 64'h4004);
      @(negedge clk);
      op_valid = 1'b0;
      chk("R2 trap from low flag", 64'(trap_req), 64'd1);
      chk("R3 disabled high flag dropped", stat_out[4:0], 64'd1);
      @(negedge clk);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule